// File: doc/BRIEF.md
# PWM DC Offset Duty Monitor

This block watches the four switching legs of a two-channel bridge-tied class-D output stage and raises a fault when a channel carries a lasting DC component. For every PWM period it counts how many clock cycles the positive leg and the negative leg of each channel spend high. The difference between the two counts is the signed differential duty of that period. A shared frame timer defines where each period starts and ends.

When the magnitude of that difference reaches the threshold, a per-channel persistence timer starts. The timer keeps running only while every following period keeps the same sign. A sign reversal or a period below the threshold restarts it. When the timer passes the qualifying time, the fault flag sets. The flag stays set until reset, which stands in for a supply cycle.

The monitor enable gates all measurement, for example during shutdown or power-up. While it is low, the counters and timers are held clear. The enable does not touch a fault that is already set. Slow alternating content whose half-periods outlast the qualifying time trips the monitor in the same way as true DC.

Top module: `dc_offset_monitor`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `dc_fault` is 0.
- R2: Each channel is judged on its own. An imbalance on channel 0 alone, or on channel 1 alone, is enough to set `dc_fault`.
- R3: A period counts as imbalanced when |pos_high − neg_high| × 100 ≥ THRESH_PCT × PERIOD_CYC. The high counts are in clock cycles, and bit i of `leg_pos`/`leg_neg` is channel i. With PERIOD_CYC = 100 and THRESH_PCT = 14, 57/43 trips and 57/44 or 44/57 does not.
- R4: Both signs trip: a positive leg high longer than the negative leg, and the reverse.
- R5: After a lasting imbalance begins, `dc_fault` stays 0 for at least HOLD_CYC − PERIOD_CYC cycles. It is 1 within HOLD_CYC + 3·PERIOD_CYC cycles. HOLD_CYC = CLK_FREQ_HZ/1000 × HOLD_MS.
- R6: A change of sign restarts the qualifying interval. An imbalance that flips sign more often than the qualifying time never sets the fault.
- R7: A period below the threshold restarts the qualifying interval.
- R8: Alternating imbalance whose half-period is longer than the qualifying time sets the fault.
- R9: Once set, `dc_fault` holds. Dropping `mon_en` or removing the imbalance does not clear it; only `rst` does.
- R10: While `mon_en` is 0, no measurement takes place and timers are held cleared. The fault cannot set from an imbalance present only while disabled, and timing restarts when the enable returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (supply-cycle model) |
| mon_en | input | 1 | Monitor enable; low holds all measurement cleared |
| leg_pos | input | NUM_CH | Positive-side PWM leg level per channel |
| leg_neg | input | NUM_CH | Negative-side PWM leg level per channel |
| dc_fault | output | 1 | Sticky DC fault flag |

## Verification
The fault is due several stages after a stimulus change:
- The imbalance first shows in the period that closes up to one PWM period later.
- The duty difference and the sign class each take one register.
- The timer then needs HOLD_CYC cycles.
- The trip register and the fault register each add one cycle.

Because the bench's PWM phase is not tied to the monitor's frame, each fault check uses a window. It expects 0 no later than HOLD_CYC − PERIOD_CYC cycles after the change, and 1 at HOLD_CYC + 3·PERIOD_CYC or later. All values are sampled on the falling clock edge.

// File: rtl/dcmon_pkg.sv
package dcmon_pkg;
  typedef enum logic [1:0] {
    POL_NONE = 2'd0,
    POL_POS  = 2'd1,
    POL_NEG  = 2'd2
  } pol_e;
endpackage

// File: rtl/dcmon_frame_timer.sv
module dcmon_frame_timer #(
  parameter int PERIOD_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic frame_last
);
  localparam int CW = $clog2(PERIOD_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (cnt == CW'(PERIOD_CYC - 1)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign frame_last = en && (cnt == CW'(PERIOD_CYC - 1));

  // R3: a measurement window never runs past its configured length
  a_r3_frame_len: assert property (@(posedge clk) disable iff (rst)
    32'(cnt) < PERIOD_CYC);
endmodule

// File: rtl/dcmon_duty_meter.sv
module dcmon_duty_meter #(
  parameter int PERIOD_CYC = 1000,
  parameter int CNT_W      = $clog2(PERIOD_CYC + 1),
  parameter int DIFF_W     = CNT_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     frame_last,
  input  logic                     leg_p,
  input  logic                     leg_n,
  output logic signed [DIFF_W-1:0] diff,
  output logic                     diff_vld
);
  logic [CNT_W-1:0] p_cnt, n_cnt;
  logic [CNT_W-1:0] p_tot, n_tot;

  assign p_tot = p_cnt + CNT_W'(leg_p);
  assign n_tot = n_cnt + CNT_W'(leg_n);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      p_cnt    <= '0;
      n_cnt    <= '0;
      diff     <= '0;
      diff_vld <= 1'b0;
    end else begin
      diff_vld <= frame_last;
      if (frame_last) begin
        diff  <= $signed({1'b0, p_tot}) - $signed({1'b0, n_tot});
        p_cnt <= '0;
        n_cnt <= '0;
      end else begin
        p_cnt <= p_tot;
        n_cnt <= n_tot;
      end
    end
  end

  // R3: high-time counts stay within one period
  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    (32'(p_cnt) <= PERIOD_CYC) && (32'(n_cnt) <= PERIOD_CYC));

  // R10: disabling clears the accumulated counts
  a_r10_meter_clear: assert property (@(posedge clk) disable iff (rst)
    !en |=> (p_cnt == '0 && n_cnt == '0 && !diff_vld));
endmodule

// File: rtl/dcmon_polarity_class.sv
module dcmon_polarity_class
  import dcmon_pkg::*;
#(
  parameter int PERIOD_CYC = 1000,
  parameter int THRESH_PCT = 14,
  parameter int DIFF_W     = 11
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic signed [DIFF_W-1:0] diff,
  input  logic                     diff_vld,
  output pol_e                     pol,
  output logic                     pol_vld
);
  localparam logic [31:0] LIMIT_X100 = 32'(THRESH_PCT * PERIOD_CYC);

  logic [DIFF_W-1:0] mag;
  logic [31:0]       scaled;
  logic              over;

  assign mag    = diff[DIFF_W-1] ? DIFF_W'(-diff) : DIFF_W'(diff);
  assign scaled = 32'(mag) * 32'd100;
  assign over   = scaled >= LIMIT_X100;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pol     <= POL_NONE;
      pol_vld <= 1'b0;
    end else begin
      pol_vld <= diff_vld;
      if (diff_vld) begin
        if (!over)                pol <= POL_NONE;
        else if (diff[DIFF_W-1])  pol <= POL_NEG;
        else                      pol <= POL_POS;
      end
    end
  end

  // R3: a new class is only published after a closed measurement period
  a_r3_class_follows_frame: assert property (@(posedge clk) disable iff (rst)
    pol_vld |-> $past(diff_vld));
endmodule

// File: rtl/dcmon_persist_timer.sv
module dcmon_persist_timer
  import dcmon_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 4200
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  pol_e pol,
  input  logic pol_vld,
  output logic trip
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  pol_e          cur_pol;
  logic [HW-1:0] cnt;
  logic          restart;

  assign restart = pol_vld && (pol != cur_pol);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cur_pol <= POL_NONE;
      cnt     <= '0;
      trip    <= 1'b0;
    end else begin
      trip <= (cur_pol != POL_NONE) && (cnt == HW'(HOLD_CYC)) && !restart;
      if (restart) begin
        cur_pol <= pol;
        cnt     <= '0;
      end else if (cur_pol != POL_NONE && cnt != HW'(HOLD_CYC)) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R5: a trip only follows a completed qualifying interval
  a_r5_trip_after_hold: assert property (@(posedge clk) disable iff (rst)
    trip |-> ($past(cnt) == HW'(HOLD_CYC)));

  // R6: a trip needs a held, signed imbalance
  a_r6_trip_has_sign: assert property (@(posedge clk) disable iff (rst)
    trip |-> ($past(cur_pol) != POL_NONE));

  // R10: disabled timers are held clear
  a_r10_timer_clear: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0 && !trip && cur_pol == POL_NONE));
endmodule

// File: rtl/dc_offset_monitor.sv
module dc_offset_monitor
  import dcmon_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int PERIOD_CYC  = 1000,
  parameter int THRESH_PCT  = 14,
  parameter int CLK_FREQ_HZ = 250_000_000,
  parameter int HOLD_MS     = 420
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mon_en,
  input  logic [NUM_CH-1:0] leg_pos,
  input  logic [NUM_CH-1:0] leg_neg,
  output logic              dc_fault
);
  localparam int unsigned HOLD_CYC = (CLK_FREQ_HZ / 1000) * HOLD_MS;
  localparam int CNT_W  = $clog2(PERIOD_CYC + 1);
  localparam int DIFF_W = CNT_W + 1;

  logic              frame_last;
  logic [NUM_CH-1:0] trip_vec;

  dcmon_frame_timer #(.PERIOD_CYC(PERIOD_CYC)) u_frame (
    .clk(clk), .rst(rst), .en(mon_en), .frame_last(frame_last)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic signed [DIFF_W-1:0] diff;
    logic                     diff_vld;
    pol_e                     pol;
    logic                     pol_vld;

    dcmon_duty_meter #(
      .PERIOD_CYC(PERIOD_CYC), .CNT_W(CNT_W), .DIFF_W(DIFF_W)
    ) u_meter (
      .clk(clk), .rst(rst), .en(mon_en), .frame_last(frame_last),
      .leg_p(leg_pos[ch]), .leg_n(leg_neg[ch]),
      .diff(diff), .diff_vld(diff_vld)
    );

    dcmon_polarity_class #(
      .PERIOD_CYC(PERIOD_CYC), .THRESH_PCT(THRESH_PCT), .DIFF_W(DIFF_W)
    ) u_class (
      .clk(clk), .rst(rst), .en(mon_en), .diff(diff), .diff_vld(diff_vld),
      .pol(pol), .pol_vld(pol_vld)
    );

    dcmon_persist_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
      .clk(clk), .rst(rst), .en(mon_en), .pol(pol), .pol_vld(pol_vld),
      .trip(trip_vec[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)            dc_fault <= 1'b0;
    else if (|trip_vec) dc_fault <= 1'b1;
  end

  // R1: reset clears the flag
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> !dc_fault);

  // R9: the flag is sticky until reset
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    dc_fault |=> dc_fault);

  // R2: the flag only rises after some channel tripped
  a_r2_rise_from_trip: assert property (@(posedge clk) disable iff (rst)
    $rose(dc_fault) |-> $past(|trip_vec));
endmodule

// File: tb/dc_offset_monitor_bench.sv
module dc_offset_monitor_bench;
  localparam int PER  = 100;
  localparam int CLKF = 10_000;
  localparam int HMS  = 420;
  localparam int HOLD = (CLKF / 1000) * HMS;
  localparam int NV   = 8;
  // {pos0, neg0, pos1, neg1, expected fault}
  localparam int VEC [NV][5] = '{
    '{50, 50, 50, 50, 0},
    '{57, 43, 50, 50, 1},
    '{43, 57, 50, 50, 1},
    '{57, 44, 50, 50, 0},
    '{50, 50, 70, 30, 1},
    '{0,  0,  0,  0,  0},
    '{50, 50, 100, 0, 1},
    '{50, 50, 44, 57, 0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mon_en = 1'b0;
  logic [1:0] leg_pos, leg_neg;
  logic       dc_fault;

  int dpos [2] = '{50, 50};
  int dneg [2] = '{50, 50};
  int flip_half = 0;
  int t_start = 0;
  int cyc = 0;
  int gcnt = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dc_offset_monitor #(
    .NUM_CH(2), .PERIOD_CYC(PER), .THRESH_PCT(14),
    .CLK_FREQ_HZ(CLKF), .HOLD_MS(HMS)
  ) u_dc_offset_monitor (
    .clk(clk), .rst(rst), .mon_en(mon_en),
    .leg_pos(leg_pos), .leg_neg(leg_neg), .dc_fault(dc_fault)
  );

  // PWM generator: drives legs just after each rising edge
  initial begin
    leg_pos = '0;
    leg_neg = '0;
    forever begin
      @(posedge clk);
      #1;
      cyc = cyc + 1;
      for (int ch = 0; ch < 2; ch++) begin
        bit inv;
        inv = (flip_half != 0) && ((((cyc - t_start) / flip_half) % 2) == 1);
        leg_pos[ch] = inv ? (gcnt < dneg[ch]) : (gcnt < dpos[ch]);
        leg_neg[ch] = inv ? (gcnt < dpos[ch]) : (gcnt < dneg[ch]);
      end
      gcnt = (gcnt == PER - 1) ? 0 : gcnt + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: dc_fault actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_duty(input int p0, input int n0, input int p1, input int n1);
    dpos[0] = p0; dneg[0] = n0; dpos[1] = p1; dneg[1] = n1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    run(5);
    rst = 1'b0;
  endtask

  initial begin
    // R1: reset state, even with a heavy imbalance present
    set_duty(100, 0, 50, 50);
    mon_en = 1'b1;
    run(5);
    chk("R1 during reset", int'(dc_fault), 0);
    rst = 1'b0;
    run(1);
    chk("R1 after reset", int'(dc_fault), 0);

    // R2 R3 R4 R5: vector table
    for (int v = 0; v < NV; v++) begin
      set_duty(50, 50, 50, 50);
      mon_en = 1'b1;
      do_reset();
      run(2 * PER);
      set_duty(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      run(HOLD - PER);
      chk($sformatf("R5 early vector %0d", v), int'(dc_fault), 0);
      run(4 * PER);
      chk($sformatf("R2/R3/R4 vector %0d", v), int'(dc_fault), VEC[v][4]);
    end

    // R6: sign flips faster than the qualifying time
    set_duty(50, 50, 50, 50);
    do_reset();
    t_start = cyc;
    flip_half = 2000;
    set_duty(70, 30, 50, 50);
    run(12000);
    chk("R6 fast sign reversal", int'(dc_fault), 0);

    // R8: slow alternating imbalance
    set_duty(50, 50, 50, 50);
    do_reset();
    t_start = cyc;
    flip_half = 6000;
    set_duty(70, 30, 50, 50);
    run(HOLD + 3 * PER);
    chk("R8 slow alternation", int'(dc_fault), 1);
    flip_half = 0;

    // R7: a balanced gap restarts the interval
    set_duty(50, 50, 50, 50);
    do_reset();
    run(2 * PER);
    set_duty(50, 50, 30, 70);
    run(2000);
    set_duty(50, 50, 50, 50);
    run(500);
    set_duty(50, 50, 30, 70);
    run(HOLD + 3 * PER - 2500);
    chk("R7 gap restarts timer", int'(dc_fault), 0);
    run(2500 + 3 * PER);
    chk("R7 trips after restart", int'(dc_fault), 1);

    // R10: disabled monitoring
    set_duty(50, 50, 50, 50);
    do_reset();
    mon_en = 1'b0;
    set_duty(80, 20, 20, 80);
    run(8000);
    chk("R10 no fault while disabled", int'(dc_fault), 0);
    mon_en = 1'b1;
    run(HOLD - PER);
    chk("R10 timing restarts on enable", int'(dc_fault), 0);
    run(4 * PER);
    chk("R10 trips after enable", int'(dc_fault), 1);

    // R9: sticky against enable and imbalance removal, cleared by reset
    mon_en = 1'b0;
    run(1000);
    chk("R9 held with enable low", int'(dc_fault), 1);
    set_duty(50, 50, 50, 50);
    mon_en = 1'b1;
    run(1000);
    chk("R9 held after imbalance removed", int'(dc_fault), 1);
    do_reset();
    run(1);
    chk("R9 reset clears", int'(dc_fault), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule